// File: doc/BRIEF.md
# Memory map chip-select decoder

This block sits beside an 8-bit microcontroller core and turns each bus cycle into region selects. The selects cover the core's own registers, the on-chip peripheral registers, RAM, the boot ROM, and two external ROM windows. For external cycles it also drives active-low read and write strobes and two active-low chip selects. One chip select serves the banked window. The other serves every flat (non-banked) external ROM range.

The block holds two control bits, each written through a small port that carries a bit index and a data bit. The overlay bit picks whether the boot ROM or external ROM answers the top 512 bytes. It comes out of reset set, so the boot ROM is mapped there. The park-suppress bit keeps the flat-ROM chip select quiet while the core sits on address FFFF in its low-power state.

On each rising edge the block samples the address, the direction and the access strobe. Its outputs come combinationally from that sample. They are also gated by the live access strobe, so they drop in the same cycle the strobe falls. The control pins are plain level signals and have no handshake.

Top module: `memmap_csdec`

## Requirements
- R1: A valid access decodes to exactly one bit of region_sel, from the address sampled at the previous rising edge. The bits are:
  - bit0: core registers, 0000-001F.
  - bit1: peripheral registers, 0020-007F.
  - bit2: RAM, 0080-17FF.
  - bit3: flat external ROM, which is 1800-7FFF, C000-FDFF, and FE00-FFFF when the overlay bit is 0.
  - bit4: banked external ROM, 8000-BFFF.
  - bit5: boot ROM, FE00-FFFF when the overlay bit is 1.
- R2: The overlay bit (cfg_idx 0) is 1 after reset, so FE00-FFFF selects region_sel bit5. It returns to 1 whenever reset is applied again.
- R3: Writing 0 to the overlay bit (cfg_we=1, cfg_idx=0, cfg_bit=0) routes FE00-FFFF to region_sel bit3, and cs_flat_n then asserts there. Writing 1 restores the boot ROM.
- R4: The park-suppress bit (cfg_idx 1) is 0 after reset. While it is 0, address FFFF decodes like any other address.
- R5: With the park-suppress bit at 1 and the overlay bit at 0, an access to FFFF still selects region_sel bit3, but cs_flat_n, oe_n and we_n stay high. Other addresses, such as FFFE, are unaffected.
- R6: cs_bank_n is low only for banked accesses. cs_flat_n is low only for flat external accesses that R5 does not suppress.
- R7: oe_n is low on external reads (rw=1) and we_n is low on external writes (rw=0). They are never low together, and neither goes low for an internal region.
- R8: While acc_vld is low, region_sel is 0 and all four strobes are high. When acc_vld falls, they deassert in that same cycle, before the next clock edge.
- R9: A change of address while acc_vld stays high reaches the outputs only after the next rising edge.
- R10: While rst_n is low, region_sel is 0 and all strobes are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Core address bus |
| rw | input | 1 | 1 = read, 0 = write |
| acc_vld | input | 1 | Access strobe, high for a bus cycle |
| cfg_we | input | 1 | Control-bit write enable |
| cfg_idx | input | 1 | Control bit index: 0 = overlay, 1 = park-suppress |
| cfg_bit | input | 1 | Value to write |
| region_sel | output | 6 | One-hot region select (see R1) |
| oe_n | output | 1 | External output enable, active low |
| we_n | output | 1 | External write strobe, active low |
| cs_flat_n | output | 1 | Flat external ROM chip select, active low |
| cs_bank_n | output | 1 | Banked external ROM chip select, active low |

## Verification
The two control bits are the only internal state besides the sampled bus cycle. A wrong overlay bit shows on the first access to FE00-FFFF: bit5 and bit3 of region_sel trade places, and cs_flat_n and oe_n change with them. A wrong park-suppress bit appears only on an access to FFFF with the overlay cleared. There, cs_flat_n goes low when it should stay high, or the reverse. A stale sampled address or valid flag shows one cycle after the bus changes, or as strobes that linger after acc_vld falls. The bench therefore checks each of these in the cycle right after the stimulus.

// File: rtl/memmap_pkg.sv
package memmap_pkg;
  localparam int ADDR_W     = 16;
  localparam int NREG       = 6;
  localparam int NRANGE     = 7;
  localparam int NCFG       = 2;
  localparam int CFG_IDX_W  = (NCFG > 1) ? $clog2(NCFG) : 1;

  localparam int RG_CORE    = 0;
  localparam int RG_PERIPH  = 1;
  localparam int RG_RAM     = 2;
  localparam int RG_XFLAT   = 3;
  localparam int RG_XBANK   = 4;
  localparam int RG_BOOT    = 5;

  localparam int CFG_OVL    = 0;
  localparam int CFG_PARK   = 1;
  localparam logic [NCFG-1:0] CFG_RST = 2'b01;

  localparam int TOP_RANGE  = NRANGE - 1;

  function automatic logic [ADDR_W-1:0] range_hi(input int i);
    case (i)
      0:       range_hi = 16'h001F;
      1:       range_hi = 16'h007F;
      2:       range_hi = 16'h17FF;
      3:       range_hi = 16'h7FFF;
      4:       range_hi = 16'hBFFF;
      5:       range_hi = 16'hFDFF;
      default: range_hi = 16'hFFFF;
    endcase
  endfunction

  function automatic int range_region(input int i);
    case (i)
      0:       range_region = RG_CORE;
      1:       range_region = RG_PERIPH;
      2:       range_region = RG_RAM;
      3:       range_region = RG_XFLAT;
      4:       range_region = RG_XBANK;
      default: range_region = RG_XFLAT;
    endcase
  endfunction
endpackage

// File: rtl/memmap_bus_capture.sv
module memmap_bus_capture
  import memmap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rw,
  input  logic              acc_vld,
  output logic [ADDR_W-1:0] addr_q,
  output logic              rw_q,
  output logic              vld_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rw_q   <= 1'b1;
      vld_q  <= 1'b0;
    end else begin
      addr_q <= addr;
      rw_q   <= rw;
      vld_q  <= acc_vld;
    end
  end
endmodule

// File: rtl/memmap_cfg_regs.sv
module memmap_cfg_regs
  import memmap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic                 cfg_bit,
  output logic [NCFG-1:0]      cfg_q
);
  for (genvar i = 0; i < NCFG; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_q[i] <= CFG_RST[i];
      end else if (cfg_we && (cfg_idx == CFG_IDX_W'(i))) begin
        cfg_q[i] <= cfg_bit;
      end
    end
  end
endmodule

// File: rtl/memmap_region_dec.sv
module memmap_region_dec
  import memmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              live,
  input  logic              boot_ovl,
  output logic [NREG-1:0]   sel
);
  int unsigned idx;

  always_comb begin
    idx = TOP_RANGE;
    for (int i = NRANGE - 2; i >= 0; i--) begin
      if (addr_q <= range_hi(i)) idx = i;
    end
  end

  always_comb begin
    sel = '0;
    if (live) begin
      if (idx == TOP_RANGE) begin
        if (boot_ovl) sel[RG_BOOT]  = 1'b1;
        else          sel[RG_XFLAT] = 1'b1;
      end else begin
        sel[range_region(idx)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/memmap_strobe_gen.sv
module memmap_strobe_gen
  import memmap_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_q,
  input  logic              rw_q,
  input  logic [NREG-1:0]   sel,
  input  logic              park_en,
  output logic              oe_n,
  output logic              we_n,
  output logic              cs_flat_n,
  output logic              cs_bank_n
);
  logic parked;
  logic flat_hit;
  logic bank_hit;
  logic ext_hit;

  always_comb begin
    parked    = park_en && (addr_q == {ADDR_W{1'b1}});
    flat_hit  = sel[RG_XFLAT] && !parked;
    bank_hit  = sel[RG_XBANK];
    ext_hit   = flat_hit || bank_hit;
    cs_flat_n = !flat_hit;
    cs_bank_n = !bank_hit;
    oe_n      = !(ext_hit && rw_q);
    we_n      = !(ext_hit && !rw_q);
  end
endmodule

// File: rtl/memmap_csdec.sv
module memmap_csdec
  import memmap_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 rw,
  input  logic                 acc_vld,
  input  logic                 cfg_we,
  input  logic [CFG_IDX_W-1:0] cfg_idx,
  input  logic                 cfg_bit,
  output logic [NREG-1:0]      region_sel,
  output logic                 oe_n,
  output logic                 we_n,
  output logic                 cs_flat_n,
  output logic                 cs_bank_n
);
  logic [ADDR_W-1:0] addr_q;
  logic              rw_q;
  logic              vld_q;
  logic [NCFG-1:0]   cfg_q;
  logic              live;

  memmap_bus_capture u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .rw      (rw),
    .acc_vld (acc_vld),
    .addr_q  (addr_q),
    .rw_q    (rw_q),
    .vld_q   (vld_q)
  );

  memmap_cfg_regs u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_we  (cfg_we),
    .cfg_idx (cfg_idx),
    .cfg_bit (cfg_bit),
    .cfg_q   (cfg_q)
  );

  assign live = vld_q && acc_vld && rst_n;

  memmap_region_dec u_dec (
    .addr_q   (addr_q),
    .live     (live),
    .boot_ovl (cfg_q[CFG_OVL]),
    .sel      (region_sel)
  );

  memmap_strobe_gen u_stb (
    .addr_q    (addr_q),
    .rw_q      (rw_q),
    .sel       (region_sel),
    .park_en   (cfg_q[CFG_PARK]),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .cs_flat_n (cs_flat_n),
    .cs_bank_n (cs_bank_n)
  );
endmodule

// File: rtl/memmap_csdec_chk.sv
module memmap_csdec_chk
  import memmap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rw,
  input logic              acc_vld,
  input logic [NREG-1:0]   region_sel,
  input logic              oe_n,
  input logic              we_n,
  input logic              cs_flat_n,
  input logic              cs_bank_n
);
  // R1
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(region_sel));

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!oe_n && !we_n));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_vld |-> (region_sel == '0) && oe_n && we_n && cs_flat_n && cs_bank_n);

  // R6
  bank_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_bank_n |-> region_sel[RG_XBANK] && cs_flat_n);

  // R6
  flat_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_flat_n |-> region_sel[RG_XFLAT]);

  // R9
  bank_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(acc_vld) && acc_vld &&
    ($past(addr) >= 16'h8000) && ($past(addr) <= 16'hBFFF) |-> !cs_bank_n);

  // R7
  read_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !oe_n |-> $past(rw));
endmodule

bind memmap_csdec memmap_csdec_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .rw         (rw),
  .acc_vld    (acc_vld),
  .region_sel (region_sel),
  .oe_n       (oe_n),
  .we_n       (we_n),
  .cs_flat_n  (cs_flat_n),
  .cs_bank_n  (cs_bank_n)
);

// File: tb/memmap_csdec_tb_top.sv
`timescale 1ns/1ps
module memmap_csdec_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        rw = 1'b1;
  logic        acc_vld = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_idx = 1'b0;
  logic        cfg_bit = 1'b0;
  logic [5:0]  region_sel;
  logic        oe_n, we_n, cs_flat_n, cs_bank_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  memmap_csdec dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rw(rw), .acc_vld(acc_vld),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_bit(cfg_bit),
    .region_sel(region_sel), .oe_n(oe_n), .we_n(we_n),
    .cs_flat_n(cs_flat_n), .cs_bank_n(cs_bank_n)
  );

  // vector: {addr[16], rw, sel[6], oe_n, we_n, cs_flat_n, cs_bank_n}
  localparam int NV = 14;
  localparam logic [26:0] VEC [NV] = '{
    {16'h0000, 1'b1, 6'b000001, 4'b1111},
    {16'h001F, 1'b0, 6'b000001, 4'b1111},
    {16'h0020, 1'b1, 6'b000010, 4'b1111},
    {16'h007F, 1'b1, 6'b000010, 4'b1111},
    {16'h0080, 1'b0, 6'b000100, 4'b1111},
    {16'h17FF, 1'b1, 6'b000100, 4'b1111},
    {16'h1800, 1'b1, 6'b001000, 4'b0101},
    {16'h7FFF, 1'b0, 6'b001000, 4'b1001},
    {16'h8000, 1'b1, 6'b010000, 4'b0110},
    {16'hBFFF, 1'b0, 6'b010000, 4'b1010},
    {16'hC000, 1'b1, 6'b001000, 4'b0101},
    {16'hFDFF, 1'b0, 6'b001000, 4'b1001},
    {16'hFE00, 1'b1, 6'b100000, 4'b1111},
    {16'hFFFF, 1'b1, 6'b100000, 4'b1111}
  };

  function automatic logic [9:0] outs();
    return {region_sel, oe_n, we_n, cs_flat_n, cs_bank_n};
  endfunction

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic idx, input logic val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = idx; cfg_bit = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // present one access, check one cycle later, then drop strobe and check idle at once
  task automatic access(input string tag, input logic [15:0] a, input logic r, input logic [9:0] exp);
    @(negedge clk);
    addr = a; rw = r; acc_vld = 1'b1;
    @(negedge clk);
    check(tag, outs(), exp);
    acc_vld = 1'b0;
    #1;
    check({tag, " R8 drop"}, outs(), 10'b0000001111);
  endtask

  initial begin
    // R10: outputs idle during reset even with strobe high
    acc_vld = 1'b1; addr = 16'h8000;
    repeat (3) @(negedge clk);
    check("R10 reset", outs(), 10'b0000001111);
    acc_vld = 1'b0;
    rst_n = 1'b1;

    // R1 R6 R7 table walk with reset control values (R2 overlay set, R4 park clear)
    for (int i = 0; i < NV; i++) begin
      access($sformatf("R1 vec%0d", i), VEC[i][26:11], VEC[i][10], VEC[i][9:0]);
    end

    // R8: strobe low, address in bank window
    @(negedge clk); addr = 16'h9000; rw = 1'b1; acc_vld = 1'b0;
    @(negedge clk);
    check("R8 idle", outs(), 10'b0000001111);

    // R9: address change while strobe held
    @(negedge clk); addr = 16'h8000; rw = 1'b1; acc_vld = 1'b1;
    @(negedge clk);
    addr = 16'h0080;
    #1;
    check("R9 hold", outs(), 10'b0100000110);
    @(negedge clk);
    check("R9 update", outs(), 10'b0001001111);
    acc_vld = 1'b0;

    // R3: clear overlay
    cfg_write(1'b0, 1'b0);
    access("R3 FE00", 16'hFE00, 1'b1, 10'b0010000101);
    access("R4 FFFF", 16'hFFFF, 1'b1, 10'b0010000101);
    access("R4 FFFF wr", 16'hFFFF, 1'b0, 10'b0010001001);

    // R5: park suppress
    cfg_write(1'b1, 1'b1);
    access("R5 FFFF rd", 16'hFFFF, 1'b1, 10'b0010001111);
    access("R5 FFFF wr", 16'hFFFF, 1'b0, 10'b0010001111);
    access("R5 FFFE", 16'hFFFE, 1'b1, 10'b0010000101);
    access("R5 bank", 16'h8001, 1'b0, 10'b0100001010);

    // R3: overlay back on, FFFF to boot ROM
    cfg_write(1'b0, 1'b1);
    access("R3 restore", 16'hFFFF, 1'b1, 10'b1000001111);

    // R2 R4: re-reset restores control bits
    cfg_write(1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    access("R2 re-reset", 16'hFE00, 1'b1, 10'b1000001111);
    cfg_write(1'b0, 1'b0);
    access("R4 re-reset", 16'hFFFF, 1'b1, 10'b0010000101);

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule